// File: doc/BRIEF.md
# System Tick Compare-Match Timer

The block watches a free-running system tick count (63 bits by default) that arrives from outside. It holds two compare registers, each one bit wider than the count. One serves the privileged level and one serves the hypervisor level. In each compare register the most significant bit masks the interrupt, and the bits below it give the count at which the comparator should fire. When the count arrives at the programmed target, the privileged comparator emits a one-cycle pulse. That pulse is meant to set bit 16 of a soft interrupt word kept elsewhere. The hypervisor comparator sets a one-bit pending flag, and a hypervisor interrupt request follows that flag.

Software reaches the two compare registers and the pending flag through one select-addressed port. Each write arms or disarms the comparator it targets. A comparator is armed only if its target is still ahead of the count at the moment of the write. It disarms when it fires or when its mask bit is set. Because of this, a target that has already passed never fires, even if the count later revisits it. While a halted input is high, hypervisor matches are consumed without any effect.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset, both compare registers read back with the mask bit (bit CNT_W) set and target 0. The pending flag reads 0, and no match pulse is active.
- R2: Select code 0 addresses the privileged compare register, code 1 the hypervisor compare register, and code 2 the pending flag at data bit 0. A write with `sw_wr_i` high takes effect at the next clock edge. Reads through `sw_rdata_o` follow the select combinationally, and code 3 reads zero.
- R3: A comparator fires when the count equals the low CNT_W bits of its register. The match output is high in the cycle after the clock edge at which the count was equal to the target.
- R4: A privileged match produces a pulse on `priv_match_o` that lasts exactly one cycle.
- R5: While the mask bit is set, reaching the target produces no pulse. Writing a value with the mask bit set cancels a pending match, and the target bits stay readable.
- R6: If a write puts the target at or behind the count present at that write, the comparator schedules no match. It stays silent even if the count later equals the target.
- R7: A comparator that is masked and then unmasked after the count has passed its target does not fire for that count.
- R8: An unmasked hypervisor match pulses `hyp_match_o` for one cycle and sets the pending flag to 1.
- R9: While `halted_i` is high at the matching edge, a hypervisor match neither pulses nor sets the pending flag.
- R10: `hyp_irq_o` is high exactly while the pending flag is 1.
- R11: When a software write to the pending flag and a hypervisor match occur at the same edge, the written value is what the flag holds afterwards.
- R12: Each arming fires at most once. If the count stays at the target, no further pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | CNT_W | Free-running system tick count |
| halted_i | input | 1 | Strand halted; suppresses hypervisor matches |
| sw_wr_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Register select: 0 privileged compare, 1 hypervisor compare, 2 pending flag |
| sw_wdata_i | input | CNT_W+1 | Write data |
| sw_rdata_o | output | CNT_W+1 | Read data of the selected register |
| priv_match_o | output | 1 | One-cycle pulse that sets soft interrupt bit 16 |
| hyp_match_o | output | 1 | One-cycle hypervisor match pulse |
| hyp_pend_o | output | 1 | Hypervisor interrupt-pending flag |
| hyp_irq_o | output | 1 | Hypervisor interrupt request |

## Verification
For each comparator, a sweep over targets 1 to 12 steps the count from 0 to 15 and checks that the pulse appears at exactly one count. This catches comparisons that are off by one, inverted, or use the wrong field. Further patterns hold the count at the target, set the target equal to or behind the count at the write, and mask the comparator before unmasking it after the count has passed. Together these separate an edge-armed comparator from a level comparator. Finally, a halted-strand pattern and a pattern that writes the pending flag in the same cycle as a match check the gating and the write priority on the hypervisor path.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;
  typedef enum logic [1:0] {
    SEL_PRIV = 2'd0,
    SEL_HYP  = 2'd1,
    SEL_PEND = 2'd2,
    SEL_NONE = 2'd3
  } tick_sel_e;

  localparam int NUM_CHAN = 2;
  localparam int CH_PRIV  = 0;
  localparam int CH_HYP   = 1;
endpackage

// File: rtl/tick_cmp_chan.sv
module tick_cmp_chan #(
  parameter int CNT_W     = 63,
  parameter bit GATE_HALT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tick_i,
  input  logic             halt_i,
  input  logic             wr_i,
  input  logic [CNT_W:0]   wdata_i,
  output logic [CNT_W:0]   cmp_o,
  output logic             fire_o,
  output logic             match_o
);
  localparam int REG_W = CNT_W + 1;

  logic [REG_W-1:0] cmp_q;
  logic             armed_q;
  logic             match_q;
  logic             hit;
  logic             gated;

  // Armed implies unmasked; mask checked again so a stale arm never fires.
  assign hit   = armed_q && !cmp_q[CNT_W] && (tick_i == cmp_q[CNT_W-1:0]);
  assign gated = GATE_HALT ? halt_i : 1'b0;
  assign fire_o = hit && !gated;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= {1'b1, {CNT_W{1'b0}}};
      armed_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= fire_o;
      if (wr_i) begin
        cmp_q   <= wdata_i;
        armed_q <= !wdata_i[CNT_W] && (wdata_i[CNT_W-1:0] > tick_i);
      end else if (hit) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign cmp_o   = cmp_q;
  assign match_o = match_q;

  p_one_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |=> !match_q);
  p_masked_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q[CNT_W] |=> !match_q);
  p_on_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_q) |-> ($past(tick_i) == $past(cmp_q[CNT_W-1:0])));
  p_halt_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (GATE_HALT && halt_i) |=> !match_q);
endmodule

// File: rtl/tick_cmp_rdmux.sv
module tick_cmp_rdmux
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W = 63
) (
  input  logic [1:0]     sel_i,
  input  logic [CNT_W:0] priv_cmp_i,
  input  logic [CNT_W:0] hyp_cmp_i,
  input  logic           pend_i,
  output logic [CNT_W:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (tick_sel_e'(sel_i))
      SEL_PRIV: rdata_o = priv_cmp_i;
      SEL_HYP:  rdata_o = hyp_cmp_i;
      SEL_PEND: rdata_o = {{CNT_W{1'b0}}, pend_i};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
  import tick_cmp_pkg::*;
#(
  parameter int CNT_W = 63
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tick_i,
  input  logic             halted_i,
  input  logic             sw_wr_i,
  input  logic [1:0]       sw_sel_i,
  input  logic [CNT_W:0]   sw_wdata_i,
  output logic [CNT_W:0]   sw_rdata_o,
  output logic             priv_match_o,
  output logic             hyp_match_o,
  output logic             hyp_pend_o,
  output logic             hyp_irq_o
);
  logic [CNT_W:0] cmp_w   [NUM_CHAN];
  logic           fire_w  [NUM_CHAN];
  logic           match_w [NUM_CHAN];
  logic           pend_q;
  logic           pend_wr;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    tick_cmp_chan #(
      .CNT_W    (CNT_W),
      .GATE_HALT(g == CH_HYP)
    ) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .halt_i (halted_i),
      .wr_i   (sw_wr_i && (sw_sel_i == 2'(g))),
      .wdata_i(sw_wdata_i),
      .cmp_o  (cmp_w[g]),
      .fire_o (fire_w[g]),
      .match_o(match_w[g])
    );
  end

  assign pend_wr = sw_wr_i && (tick_sel_e'(sw_sel_i) == SEL_PEND);

  // Software write wins over a same-cycle match.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (pend_wr)      pend_q <= sw_wdata_i[0];
    else if (fire_w[CH_HYP]) pend_q <= 1'b1;
  end

  tick_cmp_rdmux #(.CNT_W(CNT_W)) u_rdmux (
    .sel_i     (sw_sel_i),
    .priv_cmp_i(cmp_w[CH_PRIV]),
    .hyp_cmp_i (cmp_w[CH_HYP]),
    .pend_i    (pend_q),
    .rdata_o   (sw_rdata_o)
  );

  assign priv_match_o = match_w[CH_PRIV];
  assign hyp_match_o  = match_w[CH_HYP];
  assign hyp_pend_o   = pend_q;
  assign hyp_irq_o    = pend_q;

  p_match_sets_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_wr && fire_w[CH_HYP]) |=> (hyp_match_o && hyp_pend_o));
  p_sw_priority_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_wr |=> (hyp_pend_o == $past(sw_wdata_i[0])));
  p_pend_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hyp_pend_o && !pend_wr) |=> hyp_irq_o);
endmodule

// File: tb/tick_cmp_timer_test.sv
module tick_cmp_timer_test;
  localparam int CNT_W = 63;
  localparam int CLK_P = 10;
  localparam logic [CNT_W:0] MASK = {1'b1, {CNT_W{1'b0}}};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] tick = '0;
  logic             halted = 1'b0;
  logic             wr = 1'b0;
  logic [1:0]       sel = 2'd0;
  logic [CNT_W:0]   wdata = '0;
  logic [CNT_W:0]   rdata;
  logic             pm, hm, pend, irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tick_cmp_timer #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .halted_i(halted),
    .sw_wr_i(wr), .sw_sel_i(sel), .sw_wdata_i(wdata), .sw_rdata_o(rdata),
    .priv_match_o(pm), .hyp_match_o(hm), .hyp_pend_o(pend), .hyp_irq_o(irq)
  );

  task automatic chk(input string req, input logic [CNT_W:0] got, input logic [CNT_W:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic swr(input logic [1:0] s, input logic [CNT_W:0] d);
    wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic step(input int k);
    tick = CNT_W'(k);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    sel = 2'd0; #1 chk("R1 priv cmp", rdata, MASK);
    sel = 2'd1; #1 chk("R1 hyp cmp", rdata, MASK);
    sel = 2'd2; #1 chk("R1 pend", rdata, '0);
    chk("R1 pulses", {pm, hm}, '0);
    @(negedge clk);

    // R2 readback through each select code
    swr(2'd0, 64'h1234_5678_9abc);
    swr(2'd1, MASK | 64'h55);
    swr(2'd2, 64'h1);
    sel = 2'd0; #1 chk("R2 priv rd", rdata, 64'h1234_5678_9abc);
    sel = 2'd1; #1 chk("R2 hyp rd", rdata, MASK | 64'h55);
    sel = 2'd2; #1 chk("R2 pend rd", rdata, 64'h1);
    chk("R10 irq follows pend", irq, 1'b1);
    sel = 2'd3; #1 chk("R2 unused rd", rdata, '0);
    @(negedge clk);
    swr(2'd2, 64'h0);
    chk("R10 irq low", irq, 1'b0);
    swr(2'd0, MASK);

    // R3 R4 sweep for both channels, count starting at 0
    for (int ch = 0; ch < 2; ch++) begin
      for (int t = 1; t <= 12; t++) begin
        tick = '0;
        swr(2'(ch), 64'(t));
        for (int k = 0; k <= 15; k++) begin
          step(k);
          chk(ch == 0 ? "R3 R4 priv sweep" : "R3 R8 hyp sweep",
              ch == 0 ? pm : hm, (k == t));
          chk("R4 other channel idle", ch == 0 ? hm : pm, 1'b0);
        end
        if (ch == 1) begin
          chk("R8 pend set", pend, 1'b1);
          swr(2'd2, 64'h0);
        end
      end
    end

    // R12 hold count at target
    tick = '0; swr(2'd0, 64'd5);
    step(5); chk("R12 first pulse", pm, 1'b1);
    step(5); chk("R12 no repeat", pm, 1'b0);
    step(5); chk("R12 no repeat 2", pm, 1'b0);

    // R6 target at and behind count
    tick = 64'd10; swr(2'd0, 64'd10);
    step(10); chk("R6 equal target", pm, 1'b0);
    tick = 64'd10; swr(2'd0, 64'd4);
    step(4); chk("R6 behind target revisited", pm, 1'b0);

    // R5 masked target, and cancel by mask
    tick = '0; swr(2'd0, MASK | 64'd7);
    step(7); chk("R5 masked", pm, 1'b0);
    tick = '0; swr(2'd0, 64'd7);
    swr(2'd0, MASK | 64'd7);
    sel = 2'd0; #1 chk("R5 target kept", rdata, MASK | 64'd7);
    step(7); chk("R5 cancelled", pm, 1'b0);

    // R7 mask, pass target, unmask
    tick = '0; swr(2'd0, 64'd20);
    swr(2'd0, MASK | 64'd20);
    for (int k = 1; k <= 25; k++) step(k);
    swr(2'd0, 64'd20);
    step(20); chk("R7 no retroactive", pm, 1'b0);
    step(26); chk("R7 still quiet", pm, 1'b0);

    // R9 halted
    halted = 1'b1;
    tick = '0; swr(2'd1, 64'd6);
    step(6); chk("R9 no pulse halted", hm, 1'b0);
    chk("R9 no pend halted", pend, 1'b0);
    halted = 1'b0;

    // R11 software write beats same-cycle match
    tick = '0; swr(2'd1, 64'd5);
    tick = 64'd5;
    swr(2'd2, 64'h0);
    chk("R11 match pulsed", hm, 1'b1);
    chk("R11 write wins", pend, 1'b0);
    chk("R10 irq low after", irq, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule